// File: doc/BRIEF.md
# Gated 16-bit Event Counter

This block counts strobes on a count-clock enable input with a 16-bit up-counter. The counter either runs freely or counts only while a qualifying gate signal is at the active level. The gate is taken from one of four sources: an external gate pin, the period-match pulse of a built-in 8-bit companion timer, and two comparator outputs. A single polarity bit picks which gate level allows counting, whichever source is selected. A master on bit stops the counter completely.

Software reaches the count through an 8-bit register bus. A read of the low byte captures the high byte into a shadow register, so the next high-byte read returns a value that matches the low byte already read. Writes load either byte directly. When the count wraps from FFFFh to 0000h, a sticky overflow flag is set. It stays set until software writes to the flag address. The pin and comparator gate inputs are asynchronous and pass through a two-flop synchroniser. The companion timer's match pulse is already in the clock domain and is used directly.

Top module: `gated_counter`

## Requirements
- R1: After reset the count, the high-byte shadow and the overflow flag are zero, and the companion timer is at zero with its match output low.
- R2: With on=1 and gate enable=0, the count increments by one in every clock cycle in which cnt_tick_i is high.
- R3: With gate enable=1 and polarity=0, a tick increments the count only while the selected gate is low; while the gate is high the count holds.
- R4: With gate enable=1 and polarity=1, a tick increments the count only while the selected gate is high; while the gate is low the count holds.
- R5: gate_sel_i selects the gate source: 0 = gate pin, 1 = companion timer match pulse, 2 = comparator 1, 3 = comparator 2.
- R6: The companion timer advances on each aux_tick_i. On a tick taken at its period value it returns to 0 instead, and aux_match_o is high for exactly the following cycle.
- R7: With on=0, the count holds regardless of ticks and gate.
- R8: An increment from FFFFh sets ovf_flag_o. The flag stays set until a write to address 2 clears it. A set in the same cycle as a clear wins.
- R9: A read at address 0 returns count[7:0] and latches count[15:8] into a shadow. A read at address 1 returns the shadow.
- R10: A write at address 0 loads count[7:0] and a write at address 1 loads count[15:8]. A write overrides the increment in that cycle.
- R11: A change on the pin or a comparator input first affects counting at the second rising clock edge after the one that samples it.
- R12: A read at address 2 returns {7'b0, flag}; a read at address 3 returns 0. bus_rdata_o is combinational from bus_addr_i and state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_tick_i | input | 1 | Count clock strobe |
| cnt_on_i | input | 1 | Counter on |
| gate_en_i | input | 1 | Gate qualification enable |
| gate_pol_i | input | 1 | Active gate level |
| gate_sel_i | input | 2 | Gate source select |
| gate_pin_i | input | 1 | External gate pin (async) |
| cmp1_i | input | 1 | Comparator 1 output (async) |
| cmp2_i | input | 1 | Comparator 2 output (async) |
| aux_tick_i | input | 1 | Companion timer increment strobe |
| aux_period_i | input | 8 | Companion timer period |
| bus_addr_i | input | 2 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| aux_match_o | output | 1 | Companion timer match pulse |

## Verification
A wrong gate decision or a missed increment leaves a count offset that persists. It shows at the next low-byte read, which the bench issues in most cycles, so the error is seen within a few cycles. Synchroniser or source-select faults shift the count by one or more steps as soon as the gate toggles while ticks arrive. A flag fault shows on ovf_flag_o in the cycle after the wrapping increment or the clearing write. A companion timer fault shows on aux_match_o within one period.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;
  typedef enum logic [1:0] {
    SRC_PIN   = 2'd0,
    SRC_MATCH = 2'd1,
    SRC_CMP1  = 2'd2,
    SRC_CMP2  = 2'd3
  } gate_src_e;

  typedef enum logic [1:0] {
    ADR_LO   = 2'd0,
    ADR_HI   = 2'd1,
    ADR_FLAG = 2'd2,
    ADR_NONE = 2'd3
  } reg_adr_e;
endpackage

// File: rtl/gcnt_sync.sv
module gcnt_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gcnt_period_timer.sv
module gcnt_period_timer #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [PW-1:0] period_i,
  output logic          match_o
);
  logic [PW-1:0] cnt_q;
  logic          match_q;
  logic          hit;

  assign hit = (cnt_q == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= tick_i && hit;
      if (tick_i) cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
  end

  assign match_o = match_q;

  // R6
  match_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_q |-> (cnt_q == '0));
  // R6
  match_follows_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && hit) |=> match_q);
endmodule

// File: rtl/gcnt_gate_sel.sv
module gcnt_gate_sel
  import gcnt_pkg::*;
(
  input  logic      en_i,
  input  logic      pol_i,
  input  gate_src_e sel_i,
  input  logic      pin_i,
  input  logic      match_i,
  input  logic      cmp1_i,
  input  logic      cmp2_i,
  output logic      qual_o
);
  logic gate;

  always_comb begin
    unique case (sel_i)
      SRC_PIN:   gate = pin_i;
      SRC_MATCH: gate = match_i;
      SRC_CMP1:  gate = cmp1_i;
      default:   gate = cmp2_i;
    endcase
  end

  // pol selects the counting level
  assign qual_o = !en_i || (gate == pol_i);
endmodule

// File: rtl/gcnt_core.sv
module gcnt_core
  import gcnt_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic [1:0]    addr_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          flag_o
);
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] hi_buf_q;
  logic          flag_q;
  logic          wr_lo, wr_hi, wr_cnt, flag_clr, flag_set;

  assign wr_lo    = we_i && (addr_i == ADR_LO);
  assign wr_hi    = we_i && (addr_i == ADR_HI);
  assign wr_cnt   = wr_lo || wr_hi;
  assign flag_clr = we_i && (addr_i == ADR_FLAG);
  assign flag_set = inc_i && !wr_cnt && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      hi_buf_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_lo)      cnt_q[DW-1:0]  <= wdata_i;
      else if (wr_hi) cnt_q[CW-1:DW] <= wdata_i;
      else if (inc_i) cnt_q          <= cnt_q + 1'b1;
      if (re_i && addr_i == ADR_LO) hi_buf_q <= cnt_q[CW-1:DW];
      flag_q <= flag_set || (flag_q && !flag_clr);
    end
  end

  always_comb begin
    unique case (addr_i)
      ADR_LO:   rdata_o = cnt_q[DW-1:0];
      ADR_HI:   rdata_o = hi_buf_q;
      ADR_FLAG: rdata_o = {{(DW-1){1'b0}}, flag_q};
      default:  rdata_o = '0;
    endcase
  end

  assign flag_o = flag_q;

  // R2
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_cnt) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_cnt) |=> $stable(cnt_q));
  // R8
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_cnt && cnt_q == {CW{1'b1}}) |=> (flag_q && cnt_q == '0));
  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr) |=> flag_q);
  // R10
  wr_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> (cnt_q[DW-1:0] == $past(wdata_i)));
endmodule

// File: rtl/gated_counter.sv
module gated_counter
  import gcnt_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 8,
  parameter int SYNC_W = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cnt_tick_i,
  input  logic          cnt_on_i,
  input  logic          gate_en_i,
  input  logic          gate_pol_i,
  input  logic [1:0]    gate_sel_i,
  input  logic          gate_pin_i,
  input  logic          cmp1_i,
  input  logic          cmp2_i,
  input  logic          aux_tick_i,
  input  logic [PW-1:0] aux_period_i,
  input  logic [1:0]    bus_addr_i,
  input  logic          bus_we_i,
  input  logic          bus_re_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          ovf_flag_o,
  output logic          aux_match_o
);
  logic [SYNC_W-1:0] async_in, sync_out;
  logic              match, qual, inc;

  assign async_in = {cmp2_i, cmp1_i, gate_pin_i};

  gcnt_sync #(.W(SYNC_W)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(async_in), .q_o(sync_out)
  );

  gcnt_period_timer #(.PW(PW)) u_aux (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(aux_tick_i),
    .period_i(aux_period_i), .match_o(match)
  );

  gcnt_gate_sel u_gate (
    .en_i(gate_en_i), .pol_i(gate_pol_i), .sel_i(gate_src_e'(gate_sel_i)),
    .pin_i(sync_out[0]), .match_i(match), .cmp1_i(sync_out[1]),
    .cmp2_i(sync_out[2]), .qual_o(qual)
  );

  assign inc = cnt_tick_i && cnt_on_i && qual;

  gcnt_core #(.DW(DW)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc), .addr_i(bus_addr_i),
    .we_i(bus_we_i), .re_i(bus_re_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o), .flag_o(ovf_flag_o)
  );

  assign aux_match_o = match;

  // R7
  off_no_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_on_i |-> !inc);
endmodule

// File: tb/sim_gated_counter.sv
`timescale 1ns/1ps
module sim_gated_counter;
  logic clk = 0, rst_n = 0;
  logic tick = 0, on = 0, gen = 0, pol = 0;
  logic [1:0] sel = 0;
  logic pin = 0, c1 = 0, c2 = 0, atick = 0;
  logic [7:0] per = 0;
  logic [1:0] addr = 0;
  logic we = 0, re = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic ovf, amatch;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_cnt = 0;
  logic [7:0]  m_hib = 0, m_aux = 0;
  logic        m_flag = 0, m_match = 0;
  logic [2:0]  m_s1 = 0, m_s2 = 0;

  always #2 clk = ~clk;

  gated_counter u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_tick_i(tick), .cnt_on_i(on),
    .gate_en_i(gen), .gate_pol_i(pol), .gate_sel_i(sel), .gate_pin_i(pin),
    .cmp1_i(c1), .cmp2_i(c2), .aux_tick_i(atick), .aux_period_i(per),
    .bus_addr_i(addr), .bus_we_i(we), .bus_re_i(re), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .ovf_flag_o(ovf), .aux_match_o(amatch)
  );

  function automatic logic [7:0] exp_rd();
    case (addr)
      2'd0: return m_cnt[7:0];
      2'd1: return m_hib;
      2'd2: return {7'b0, m_flag};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic g, qual, inc, wlo, whi, hit;
    case (sel)
      2'd0: g = m_s2[0];
      2'd1: g = m_match;
      2'd2: g = m_s2[1];
      default: g = m_s2[2];
    endcase
    qual = !gen || (g == pol);
    inc  = tick && on && qual;
    wlo  = we && addr == 2'd0;
    whi  = we && addr == 2'd1;
    m_flag = (inc && !wlo && !whi && m_cnt == 16'hFFFF) ||
             (m_flag && !(we && addr == 2'd2));
    if (re && addr == 2'd0) m_hib = m_cnt[15:8];
    if (wlo) m_cnt[7:0] = wdata;
    else if (whi) m_cnt[15:8] = wdata;
    else if (inc) m_cnt = m_cnt + 1'b1;
    m_s2 = m_s1;
    m_s1 = {c2, c1, pin};
    hit = (m_aux == per);
    m_match = atick && hit;
    if (atick) m_aux = hit ? 8'd0 : m_aux + 1'b1;
  endtask

  // inputs already driven after a negedge; check, then advance one edge
  task automatic cyc(string tag);
    #0.5;
    chk({tag, " rdata"}, 16'(rdata), 16'(exp_rd()));
    chk("R8 flag", 16'(ovf), 16'(m_flag));
    chk("R6 match", 16'(amatch), 16'(m_match));
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic rd_lo(); re = 1; we = 0; addr = 0; endtask

  initial begin
    void'($urandom(32'd4177));
    repeat (3) @(negedge clk);
    #0.5;
    // R1 reset state
    chk("R1 ovf", 16'(ovf), 0);
    chk("R1 match", 16'(amatch), 0);
    chk("R1 lo", 16'(rdata), 0);
    rst_n = 1;
    @(negedge clk);
    addr = 1; #0.5; chk("R1 hibuf", 16'(rdata), 0);

    // R2 free run
    on = 1; gen = 0; tick = 1; rd_lo();
    repeat (20) cyc("R2");
    addr = 1; re = 1; cyc("R9 hi");
    // R7 off holds
    on = 0; rd_lo();
    repeat (10) cyc("R7");
    on = 1;
    // R10 load near wrap, R8 overflow
    tick = 0; re = 0; we = 1; addr = 1; wdata = 8'hFF; cyc("R10 wr hi");
    addr = 0; wdata = 8'hFD; tick = 1; cyc("R10 wr beats inc");
    we = 0; rd_lo();
    repeat (4) cyc("R8 wrap");
    chk("R8 set", 16'(ovf), 1);
    we = 1; addr = 2; tick = 0; cyc("R8 clear");
    we = 0; addr = 2; re = 1; cyc("R12 flag rd");
    addr = 3; cyc("R12 addr3");
    // set wins over clear
    tick = 0; we = 1; addr = 1; wdata = 8'hFF; cyc("R10");
    addr = 0; wdata = 8'hFF; cyc("R10");
    addr = 2; tick = 1; cyc("R8 set vs clr");
    chk("R8 set wins", 16'(ovf), 1);
    we = 0;
    // R11 sync latency: pin change then ticks
    gen = 1; pol = 1; sel = 0; pin = 0; tick = 1; rd_lo();
    repeat (4) cyc("R11");
    pin = 1; repeat (4) cyc("R11");
    pin = 0; repeat (4) cyc("R11");
    // R6 companion timer, R5 select match source
    per = 8'd3; atick = 1; sel = 1; pol = 1;
    repeat (16) cyc("R6 R5");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      tick  = ($urandom % 10) < 7;
      atick = ($urandom % 2) == 1;
      if (($urandom % 5) == 0) pin = ~pin;
      if (($urandom % 6) == 0) c1 = ~c1;
      if (($urandom % 7) == 0) c2 = ~c2;
      if (($urandom % 50) == 0) begin
        on  = ($urandom % 8) != 0;
        gen = ($urandom % 4) != 0;
        pol = $urandom % 2;
        sel = 2'($urandom);
        per = 8'($urandom % 6);
      end
      r = $urandom % 100;
      addr = 2'($urandom);
      re = r < 60;
      we = r >= 96;
      wdata = ($urandom % 2) ? 8'hFF : 8'($urandom);
      case (sel)
        2'd0: cyc(pol ? "R4 R5 pin" : "R3 R5 pin");
        2'd1: cyc(pol ? "R4 R5 match" : "R3 R5 match");
        2'd2: cyc(pol ? "R4 R5 cmp1" : "R3 R5 cmp1");
        default: cyc(pol ? "R4 R5 cmp2" : "R3 R5 cmp2");
      endcase
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule